// File: doc/BRIEF.md
# Cache Color Region Mapping Table

This block sits beside the last-level cache and turns a physical page number into a cache color. A color is a slice of the cache that holds one page-sized stride of every way, so the number of colors is the cache size divided by the product of page size and associativity. A 2 MB, 8-way cache with 4 KB pages has 64 colors. The low bits of the page number pick a memory region, and there are as many regions as colors. Instead of using those bits directly as the color, the block looks them up in a small rewritable table with one entry per region. Because of this indirection, all regions can be folded onto a subset of the colors, and the unused colors can then be powered down.

Software sets the number of allocated colors. The allocated set is always the lowest `m` colors. A new count is accepted only if it is even, at least one sixteenth of all colors, no larger than the total, and no more than 16 away from the current count.

- On a shrink, the block emits a one-cycle flush request with a mask of the removed colors. It then walks the table and spreads the orphaned regions round-robin over the colors that remain.
- On a grow, each newly added color takes back its own home region.

A write port lets software retarget single entries, but only onto allocated colors.

Top module: `ccm_color_map`

## Requirements
- R1: After reset every region `r` maps to color `r`, all colors are allocated, and `busy`, `cfg_err` and `flush_req` are low.
- R2: `lkp_color` is, in the same cycle, the table entry of the region given by `lkp_page[CW-1:0]`; the upper page bits have no effect.
- R3: A write with `wr_en`, when idle, no `cfg_req` and `wr_color < alloc_count`, sets the entry of `wr_region`, visible from the next cycle; any other write changes nothing and pulses `cfg_err` for one cycle after the request.
- R4: A count request is rejected (one-cycle `cfg_err` pulse the cycle after, count and table unchanged) if the count is odd, below `N_COLORS/16`, above `N_COLORS`, or differs from the current count by more than 16.
- R5: The allocated colors are 0 to `alloc_count-1`: bit `c` of `alloc_mask` is 1 exactly when `c < alloc_count`; `alloc_count` takes an accepted value one cycle after the request.
- R6: An accepted shrink raises `flush_req` for exactly one cycle, together with the accept, with `flush_mask` bit `c` set exactly for `new <= c < old`; otherwise `flush_req` is low and `flush_mask` is zero.
- R7: On a shrink to `n`, regions are visited in ascending order, and each one whose color is `>= n` is reassigned to the next color of the sequence 0, 1, ..., n-1, 0, ...; all other entries keep their color.
- R8: On a grow from `o` to `n`, every region `r` with `o <= r < n` is set to color `r`; all other entries keep their color.
- R9: After an accepted request (including an unchanged count), `busy` is high for exactly `N_COLORS` cycles; count requests and writes made while busy are rejected with `cfg_err` and have no effect.
- R10: Whenever `busy` is low, every lookup returns a color below `alloc_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_page | input | PAGE_W | Physical page number to translate |
| lkp_color | output | CW | Color of the page's region |
| wr_en | input | 1 | Single-entry remap request |
| wr_region | input | CW | Region to retarget |
| wr_color | input | CW | New color for that region |
| cfg_req | input | 1 | Request a new allocated-color count |
| cfg_count | input | CW+1 | Requested count |
| alloc_count | output | CW+1 | Current number of allocated colors |
| alloc_mask | output | N_COLORS | One bit per allocated color |
| flush_req | output | 1 | One-cycle flush request on shrink |
| flush_mask | output | N_COLORS | Colors to flush |
| busy | output | 1 | Table walk in progress |
| cfg_err | output | 1 | One-cycle pulse on a rejected request |

## Verification
The bench targets the count rule boundaries:
- the minimum of four colors and a step of exactly 16 must be accepted;
- a count of two, an odd count, a count above the total and a step of 18 must be rejected.

A design with an off-by-one in any of these checks would either move the count where it should hold still, or raise the error flag on a legal request.

The round-robin refill is checked entry by entry after shrinks that follow hand-written remaps, so entries already pointing low are left alone. A design that restarted the rotation at each region, or reassigned entries that were still valid, would show colors that differ from the model. Requests and writes arriving during the walk are checked for rejection, and the walk length is counted; a design that let them through would corrupt entries or change the count in the middle of the walk.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_SHRINK = 2'd1,
        WALK_GROW   = 2'd2
    } walk_mode_e;
endpackage

// File: rtl/ccm_cfg_check.sv
module ccm_cfg_check #(
    parameter int N_COLORS   = 64,
    parameter int MIN_COLORS = 4,
    parameter int STEP       = 2,
    parameter int MAX_DELTA  = 16,
    parameter int CNTW       = 7
) (
    input  logic [CNTW-1:0] cur_count,
    input  logic [CNTW-1:0] req_count,
    output logic            legal,
    output logic            shrink
);
    logic [CNTW-1:0] delta;

    always_comb begin
        delta  = (req_count > cur_count) ? (req_count - cur_count) : (cur_count - req_count);
        shrink = req_count < cur_count;
        legal  = ((req_count % CNTW'(STEP)) == '0)
              && (req_count >= CNTW'(MIN_COLORS))
              && (req_count <= CNTW'(N_COLORS))
              && (delta <= CNTW'(MAX_DELTA));
    end
endmodule

// File: rtl/ccm_range_mask.sv
module ccm_range_mask #(
    parameter int N_COLORS = 64,
    parameter int CNTW     = 7
) (
    input  logic [CNTW-1:0]     lo,
    input  logic [CNTW-1:0]     hi,
    output logic [N_COLORS-1:0] mask
);
    for (genvar c = 0; c < N_COLORS; c++) begin : g_bit
        assign mask[c] = (CNTW'(c) >= lo) && (CNTW'(c) < hi);
    end
endmodule

// File: rtl/ccm_color_map.sv
module ccm_color_map #(
    parameter int N_COLORS  = 64,
    parameter int PAGE_W    = 20,
    parameter int STEP      = 2,
    parameter int MAX_DELTA = 16,
    localparam int CW       = $clog2(N_COLORS),
    localparam int CNTW     = CW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAGE_W-1:0]   lkp_page,
    output logic [CW-1:0]       lkp_color,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_region,
    input  logic [CW-1:0]       wr_color,
    input  logic                cfg_req,
    input  logic [CNTW-1:0]     cfg_count,
    output logic [CNTW-1:0]     alloc_count,
    output logic [N_COLORS-1:0] alloc_mask,
    output logic                flush_req,
    output logic [N_COLORS-1:0] flush_mask,
    output logic                busy,
    output logic                cfg_err
);
    import ccm_pkg::*;

    localparam int MIN_COLORS = N_COLORS / 16;

    typedef struct packed {
        logic [N_COLORS-1:0][CW-1:0] tbl;
        logic [CNTW-1:0]             cnt;
        logic [CNTW-1:0]             old;
        walk_mode_e                  mode;
        logic [CW-1:0]               idx;
        logic [CW-1:0]               rr;
        logic                        flush;
        logic [N_COLORS-1:0]         fmask;
        logic                        err;
    } state_t;

    state_t q, d;

    logic                req_legal;
    logic                req_shrink;
    logic [N_COLORS-1:0] removed_mask;
    logic                unused_page_hi;

    ccm_cfg_check #(
        .N_COLORS  (N_COLORS),
        .MIN_COLORS(MIN_COLORS),
        .STEP      (STEP),
        .MAX_DELTA (MAX_DELTA),
        .CNTW      (CNTW)
    ) u_check (
        .cur_count(q.cnt),
        .req_count(cfg_count),
        .legal    (req_legal),
        .shrink   (req_shrink)
    );

    ccm_range_mask #(.N_COLORS(N_COLORS), .CNTW(CNTW)) u_removed (
        .lo  (cfg_count),
        .hi  (q.cnt),
        .mask(removed_mask)
    );

    ccm_range_mask #(.N_COLORS(N_COLORS), .CNTW(CNTW)) u_alloc (
        .lo  ('0),
        .hi  (q.cnt),
        .mask(alloc_mask)
    );

    always_comb begin
        d       = q;
        d.flush = 1'b0;
        d.fmask = '0;
        d.err   = 1'b0;

        if (q.mode != WALK_IDLE) begin
            // one region per cycle
            if (q.mode == WALK_SHRINK) begin
                if ({1'b0, q.tbl[q.idx]} >= q.cnt) begin
                    d.tbl[q.idx] = q.rr;
                    if (({1'b0, q.rr} + CNTW'(1)) == q.cnt) begin
                        d.rr = '0;
                    end else begin
                        d.rr = q.rr + CW'(1);
                    end
                end
            end else begin
                if (({1'b0, q.idx} >= q.old) && ({1'b0, q.idx} < q.cnt)) begin
                    d.tbl[q.idx] = q.idx;
                end
            end
            if (q.idx == CW'(N_COLORS - 1)) begin
                d.mode = WALK_IDLE;
            end
            d.idx = q.idx + CW'(1);
            if (cfg_req || wr_en) begin
                d.err = 1'b1;
            end
        end else if (cfg_req) begin
            if (req_legal) begin
                d.cnt  = cfg_count;
                d.old  = q.cnt;
                d.mode = req_shrink ? WALK_SHRINK : WALK_GROW;
                d.idx  = '0;
                d.rr   = '0;
                if (req_shrink) begin
                    d.flush = 1'b1;
                    d.fmask = removed_mask;
                end
            end else begin
                d.err = 1'b1;
            end
            if (wr_en) begin
                d.err = 1'b1;
            end
        end else if (wr_en) begin
            if ({1'b0, wr_color} < q.cnt) begin
                d.tbl[wr_region] = wr_color;
            end else begin
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_COLORS; i++) begin
                q.tbl[i] <= CW'(i);
            end
            q.cnt   <= CNTW'(N_COLORS);
            q.old   <= CNTW'(N_COLORS);
            q.mode  <= WALK_IDLE;
            q.idx   <= '0;
            q.rr    <= '0;
            q.flush <= 1'b0;
            q.fmask <= '0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign lkp_color      = q.tbl[lkp_page[CW-1:0]];
    assign unused_page_hi = ^lkp_page[PAGE_W-1:CW];
    assign alloc_count    = q.cnt;
    assign flush_req      = q.flush;
    assign flush_mask     = q.fmask;
    assign busy           = (q.mode != WALK_IDLE);
    assign cfg_err        = q.err;
endmodule

// File: rtl/ccm_checker.sv
module ccm_checker #(
    parameter int N_COLORS  = 64,
    parameter int MAX_DELTA = 16,
    parameter int CW        = 6,
    parameter int CNTW      = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CW-1:0]       lkp_color,
    input logic [CNTW-1:0]     alloc_count,
    input logic [N_COLORS-1:0] alloc_mask,
    input logic                flush_req,
    input logic [N_COLORS-1:0] flush_mask,
    input logic                busy
);
    a_r10_lookup_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({1'b0, lkp_color} < alloc_count));

    a_r5_mask_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_mask) == int'(alloc_count));

    a_r4_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_count[0] == 1'b0) && (alloc_count >= CNTW'(N_COLORS / 16))
        && (alloc_count <= CNTW'(N_COLORS)));

    a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_count > $past(alloc_count)) |-> (alloc_count - $past(alloc_count) <= CNTW'(MAX_DELTA)));

    a_r4_step_bounded_down: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_count < $past(alloc_count)) |-> ($past(alloc_count) - alloc_count <= CNTW'(MAX_DELTA)));

    a_r9_count_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_count != $past(alloc_count)) |-> $rose(busy));

    a_r6_flush_size: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> ($countones(flush_mask) == int'($past(alloc_count) - alloc_count)));

    a_r6_flush_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $rose(busy));

    a_r6_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req |-> (flush_mask == '0));
endmodule

bind ccm_color_map ccm_checker #(
    .N_COLORS (N_COLORS),
    .MAX_DELTA(MAX_DELTA),
    .CW       (CW),
    .CNTW     (CNTW)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lkp_color  (lkp_color),
    .alloc_count(alloc_count),
    .alloc_mask (alloc_mask),
    .flush_req  (flush_req),
    .flush_mask (flush_mask),
    .busy       (busy)
);

// File: tb/ccm_color_map_bench.sv
`timescale 1ns/1ps
module ccm_color_map_bench;
    localparam int N      = 64;
    localparam int PAGE_W = 20;
    localparam int CW     = 6;
    localparam int CNTW   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PAGE_W-1:0] lkp_page = '0;
    logic [CW-1:0]     lkp_color;
    logic              wr_en = 1'b0;
    logic [CW-1:0]     wr_region = '0;
    logic [CW-1:0]     wr_color = '0;
    logic              cfg_req = 1'b0;
    logic [CNTW-1:0]   cfg_count = '0;
    logic [CNTW-1:0]   alloc_count;
    logic [N-1:0]      alloc_mask;
    logic              flush_req;
    logic [N-1:0]      flush_mask;
    logic              busy;
    logic              cfg_err;

    int checks = 0;
    int errors = 0;
    int model [N];
    int mcnt = N;
    bit done = 0;

    always #4 clk = ~clk;

    ccm_color_map #(.N_COLORS(N), .PAGE_W(PAGE_W)) u_ccm_color_map (
        .clk(clk), .rst_n(rst_n), .lkp_page(lkp_page), .lkp_color(lkp_color),
        .wr_en(wr_en), .wr_region(wr_region), .wr_color(wr_color),
        .cfg_req(cfg_req), .cfg_count(cfg_count), .alloc_count(alloc_count),
        .alloc_mask(alloc_mask), .flush_req(flush_req), .flush_mask(flush_mask),
        .busy(busy), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2 R10: read every region through the lookup port with varied upper page bits
    task automatic check_table(input string req);
        int bad = 0;
        int range_bad = 0;
        for (int r = 0; r < N; r++) begin
            lkp_page = PAGE_W'((r * 977 + 5) << CW) | PAGE_W'(r);
            #1;
            if (int'(lkp_color) != model[r]) bad++;
            if (int'(lkp_color) >= mcnt) range_bad++;
        end
        check(req, "table entries differing from model", 64'(bad), 64'd0);
        check("R10", "lookups at or above count", 64'(range_bad), 64'd0);
    endtask

    function automatic logic [63:0] exp_mask(input int lo, input int hi);
        logic [63:0] m = '0;
        for (int c = 0; c < N; c++) if (c >= lo && c < hi) m[c] = 1'b1;
        return m;
    endfunction

    task automatic update_model(input int n);
        if (n < mcnt) begin
            int rr = 0;
            for (int r = 0; r < N; r++) begin
                if (model[r] >= n) begin
                    model[r] = rr;
                    rr = (rr + 1) % n;
                end
            end
        end else begin
            for (int r = mcnt; r < n; r++) model[r] = r;
        end
        mcnt = n;
    endtask

    task automatic do_write(input int region, input int color, input bit ok, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_region = CW'(region); wr_color = CW'(color);
        @(negedge clk);
        wr_en = 1'b0;
        check(req, "write error flag", 64'(cfg_err), ok ? 64'd0 : 64'd1);
        if (ok) model[region] = color;
        check_table(req);
    endtask

    task automatic do_cfg(input int n, input bit ok, input string req);
        int cycles = 0;
        @(negedge clk);
        cfg_req = 1'b1; cfg_count = CNTW'(n);
        @(negedge clk);
        cfg_req = 1'b0;
        check(req, "request error flag", 64'(cfg_err), ok ? 64'd0 : 64'd1);
        check(ok ? "R5" : "R4", "count after request", 64'(alloc_count), ok ? 64'(n) : 64'(mcnt));
        check("R5", "allocated mask", 64'(alloc_mask), ok ? exp_mask(0, n) : exp_mask(0, mcnt));
        if (ok) begin
            check("R6", "flush request", 64'(flush_req), (n < mcnt) ? 64'd1 : 64'd0);
            check("R6", "flush mask", 64'(flush_mask), (n < mcnt) ? exp_mask(n, mcnt) : 64'd0);
            while (busy && cycles < 200) begin
                cycles++;
                @(negedge clk);
                if (cycles == 1) check("R6", "flush pulse length", 64'(flush_req), 64'd0);
            end
            check("R9", "busy cycles", 64'(cycles), 64'(N));
            update_model(n);
        end else begin
            check("R4", "busy after rejected request", 64'(busy), 64'd0);
        end
        check_table(req);
    endtask

    // R9: a request and a write during the walk are both rejected
    task automatic cfg_during_busy(input int n, input int intr);
        @(negedge clk);
        cfg_req = 1'b1; cfg_count = CNTW'(n);
        @(negedge clk);
        cfg_count = CNTW'(intr); wr_en = 1'b1; wr_region = 6'd1; wr_color = 6'd0;
        check("R9", "accept before interruption", 64'(cfg_err), 64'd0);
        @(negedge clk);
        cfg_req = 1'b0; wr_en = 1'b0;
        check("R9", "error for request while busy", 64'(cfg_err), 64'd1);
        check("R9", "count kept while busy", 64'(alloc_count), 64'(n));
        while (busy) @(negedge clk);
        update_model(n);
        check_table("R9");
    endtask

    initial begin
        for (int r = 0; r < N; r++) model[r] = r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "count at reset", 64'(alloc_count), 64'(N));
        check("R1", "mask at reset", 64'(alloc_mask), {64{1'b1}});
        check("R1", "busy at reset", 64'(busy), 64'd0);
        check("R1", "error at reset", 64'(cfg_err), 64'd0);
        check("R1", "flush at reset", 64'(flush_req), 64'd0);
        check_table("R1");
        // R2 upper page bits ignored
        lkp_page = 20'hABC05; #1;
        check("R2", "page ABC05 color", 64'(lkp_color), 64'd5);
        lkp_page = 20'h0007F; #1;
        check("R2", "page 0007F color", 64'(lkp_color), 64'd63);
        // R3 writes
        do_write(5, 3, 1, "R3");
        do_write(63, 0, 1, "R3");
        // R4 illegal counts
        do_cfg(63, 0, "R4");
        do_cfg(66, 0, "R4");
        do_cfg(44, 0, "R4");
        // R7 shrink
        do_cfg(48, 1, "R7");
        do_write(7, 50, 0, "R3");
        do_write(7, 47, 1, "R3");
        do_write(2, 40, 1, "R3");
        cfg_during_busy(32, 40);
        // R8 grow
        do_cfg(48, 1, "R8");
        do_cfg(32, 1, "R7");
        do_cfg(16, 1, "R7");
        do_cfg(4, 1, "R4");
        do_cfg(2, 0, "R4");
        do_cfg(20, 1, "R8");
        do_cfg(38, 0, "R4");
        do_cfg(36, 1, "R8");
        do_cfg(36, 1, "R9");
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule